// File: doc/BRIEF.md
# Chase Test-Pattern Decoder and Candidate Selector

This block is the middle stage of a soft-input soft-output decoder for a product code built from an extended (16,11) BCH component code. The reception stage hands it four things: the hard decisions of a 16-bit word, the reliability magnitude of each bit, the syndrome of the hard bits, and the positions of the two least reliable bits. The block then forms four test patterns. Each pattern flips one combination of those two positions. Each pattern is corrected with single-error syndrome decoding, and its extension parity is then fixed. Every candidate is scored against the soft input.

One candidate is handled per clock cycle. The syndrome of each pattern is not computed again from the word. It comes from the stored syndrome, XORed with the parity-check columns of the flipped positions. After the last pattern, the block presents two results: the minimum-metric decided word, and the best distinct runner-up (the concurrent word), each with its metric. A flag is raised when no distinct competitor exists. The emission stage downstream uses these results to compute reliabilities.

Top module: `chase_tv_decoder`

## Requirements
- R1: After reset, busy_o, done_o, conc_absent_o, dec_word_o, dec_metric_o, conc_word_o and conc_metric_o are all zero.
- R2: A start_i that is sampled high while busy_o is low is accepted and captures all data inputs. busy_o is high for the following 4 cycles. done_o is high for exactly one cycle, 4 clock edges after the accepting edge, and busy_o is low during that cycle.
- R3: Test pattern t (t = 0..3) inverts the hard bit at the position in lrp_i[3:0] when bit 0 of t is set, and the hard bit at the position in lrp_i[7:4] when bit 1 of t is set. The two positions must differ.
- R4: syn_i is the XOR of alpha^j over the bits j = 0..14 that are set in hard_i, where alpha is a root of x^4+x+1 (alpha^0=1, alpha^1=2, alpha^4=3). Bit 15 has no syndrome column. The syndrome of a pattern is syn_i XOR the columns of its flipped positions. A nonzero syndrome s inverts the bit j for which alpha^j = s.
- R5: After that correction, bit 15 is inverted if the 16-bit word has odd weight. Every candidate is therefore an extended codeword.
- R6: The metric of a candidate is the sum of mag_i[3j+2:3j] over the positions j where the candidate differs from hard_i.
- R7: The decided word is the candidate with the smallest metric. On a tie, the lower pattern index wins.
- R8: The concurrent word is the candidate with the smallest metric among those that differ from the decided word. On a tie, the lower pattern index wins. When no candidate differs, conc_absent_o is 1 and conc_word_o and conc_metric_o are 0.
- R9: A start_i that arrives while busy_o is high is ignored, and its data has no effect on the result.
- R10: The result outputs and conc_absent_o keep their values from the done_o cycle until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request; accepted when idle |
| hard_i | input | 16 | Hard decisions of the word |
| mag_i | input | 48 | Reliability magnitude per bit, 3 bits each, position j at [3j+2:3j] |
| syn_i | input | 4 | Syndrome of hard bits 0..14 |
| lrp_i | input | 8 | Two least reliable positions, 4 bits each |
| busy_o | output | 1 | Test patterns being evaluated |
| done_o | output | 1 | One-cycle result-valid pulse |
| dec_word_o | output | 16 | Decided word |
| dec_metric_o | output | 8 | Metric of the decided word |
| conc_word_o | output | 16 | Concurrent word |
| conc_metric_o | output | 8 | Metric of the concurrent word |
| conc_absent_o | output | 1 | No distinct concurrent word exists |

## Verification
The codeword assertions rely on syn_i being the true syndrome of hard_i, as R4 defines it, and on the two least reliable positions being different. The bench computes syn_i from the hard word it drives on every case, and it draws the second position from the fifteen values that differ from the first. Random hard words and magnitudes exercise the ordering and tie rules. The directed cases include an all-zero word whose four patterns collapse into one candidate, and a start request injected during processing with different data.

// File: rtl/chase_pkg.sv
package chase_pkg;
  localparam int unsigned CW_N  = 16;
  localparam int unsigned SYN_W = 4;
  localparam int unsigned POS_W = $clog2(CW_N);

  // parity-check column of a position; extension bit has none
  function automatic logic [SYN_W-1:0] pc_col(input logic [POS_W-1:0] pos);
    logic [SYN_W-1:0] v;
    v = 4'd1;
    if (pos == POS_W'(CW_N-1)) return '0;
    for (int i = 0; i < int'(CW_N) - 1; i++)
      if (i < int'(pos)) v = {v[2:0], 1'b0} ^ (v[3] ? 4'b0011 : 4'b0000);
    return v;
  endfunction

  function automatic logic [POS_W-1:0] err_pos(input logic [SYN_W-1:0] s);
    logic [POS_W-1:0] p;
    p = '0;
    for (int i = 0; i < int'(CW_N) - 1; i++)
      if (pc_col(POS_W'(i)) == s) p = POS_W'(i);
    return p;
  endfunction

  function automatic logic [SYN_W-1:0] word_syn(input logic [CW_N-1:0] w);
    logic [SYN_W-1:0] s;
    s = '0;
    for (int i = 0; i < int'(CW_N); i++)
      if (w[i]) s ^= pc_col(POS_W'(i));
    return s;
  endfunction
endpackage

// File: rtl/chase_tv_gen.sv
module chase_tv_gen
  import chase_pkg::*;
#(
  parameter int unsigned LR = 2
) (
  input  logic [CW_N-1:0]     hard_i,
  input  logic [SYN_W-1:0]    syn_i,
  input  logic [LR*POS_W-1:0] lrp_i,
  input  logic [LR-1:0]       tv_idx_i,
  output logic [CW_N-1:0]     cand_o
);
  logic [CW_N-1:0]  flips;
  logic [SYN_W-1:0] s;
  logic [CW_N-1:0]  fixed;

  always_comb begin
    flips = '0;
    s     = syn_i;
    for (int k = 0; k < int'(LR); k++) begin
      if (tv_idx_i[k]) begin
        flips[lrp_i[k*POS_W +: POS_W]] = 1'b1;
        s = s ^ pc_col(lrp_i[k*POS_W +: POS_W]);
      end
    end
    fixed = hard_i ^ flips;
    if (s != '0) fixed[err_pos(s)] = ~fixed[err_pos(s)];
    if (^fixed) fixed[CW_N-1] = ~fixed[CW_N-1];
    cand_o = fixed;
  end
endmodule

// File: rtl/chase_metric.sv
module chase_metric
  import chase_pkg::*;
#(
  parameter int unsigned MAG_W = 3,
  parameter int unsigned MET_W = 8
) (
  input  logic [CW_N-1:0]       cand_i,
  input  logic [CW_N-1:0]       hard_i,
  input  logic [CW_N*MAG_W-1:0] mag_i,
  output logic [MET_W-1:0]      met_o
);
  logic [MET_W-1:0] term [CW_N];

  for (genvar j = 0; j < int'(CW_N); j++) begin : g_term
    assign term[j] = (cand_i[j] ^ hard_i[j]) ? MET_W'(mag_i[j*MAG_W +: MAG_W]) : '0;
  end

  always_comb begin
    met_o = '0;
    for (int j = 0; j < int'(CW_N); j++) met_o = met_o + term[j];
  end
endmodule

// File: rtl/chase_select.sv
module chase_select #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned MET_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              fold_i,
  input  logic [WORD_W-1:0] cand_i,
  input  logic [MET_W-1:0]  met_i,
  output logic [WORD_W-1:0] best_word_o,
  output logic [MET_W-1:0]  best_met_o,
  output logic              best_vld_o,
  output logic [WORD_W-1:0] sec_word_o,
  output logic [MET_W-1:0]  sec_met_o,
  output logic              sec_vld_o
);
  logic dup;

  // a repeat of a kept word carries the same metric; drop it
  assign dup = (best_vld_o && cand_i == best_word_o) ||
               (sec_vld_o  && cand_i == sec_word_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      best_word_o <= '0; best_met_o <= '0; best_vld_o <= 1'b0;
      sec_word_o  <= '0; sec_met_o  <= '0; sec_vld_o  <= 1'b0;
    end else if (clear_i) begin
      best_word_o <= '0; best_met_o <= '0; best_vld_o <= 1'b0;
      sec_word_o  <= '0; sec_met_o  <= '0; sec_vld_o  <= 1'b0;
    end else if (fold_i && !dup) begin
      if (!best_vld_o || met_i < best_met_o) begin
        sec_word_o  <= best_word_o;
        sec_met_o   <= best_met_o;
        sec_vld_o   <= best_vld_o;
        best_word_o <= cand_i;
        best_met_o  <= met_i;
        best_vld_o  <= 1'b1;
      end else if (!sec_vld_o || met_i < sec_met_o) begin
        sec_word_o <= cand_i;
        sec_met_o  <= met_i;
        sec_vld_o  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/chase_tv_decoder.sv
module chase_tv_decoder
  import chase_pkg::*;
#(
  parameter int unsigned MAG_W = 3,
  parameter int unsigned LR    = 2,
  localparam int unsigned MET_W = MAG_W + $clog2(CW_N + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [CW_N-1:0]       hard_i,
  input  logic [CW_N*MAG_W-1:0] mag_i,
  input  logic [SYN_W-1:0]      syn_i,
  input  logic [LR*POS_W-1:0]   lrp_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [CW_N-1:0]       dec_word_o,
  output logic [MET_W-1:0]      dec_metric_o,
  output logic [CW_N-1:0]       conc_word_o,
  output logic [MET_W-1:0]      conc_metric_o,
  output logic                  conc_absent_o
);
  logic [CW_N-1:0]       hard_q;
  logic [CW_N*MAG_W-1:0] mag_q;
  logic [SYN_W-1:0]      syn_q;
  logic [LR*POS_W-1:0]   lrp_q;
  logic [LR-1:0]         tv_cnt_q;
  logic                  accept, last;
  logic [CW_N-1:0]       cand;
  logic [MET_W-1:0]      met;
  logic                  best_vld, sec_vld;

  assign accept = start_i && !busy_o;
  assign last   = &tv_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hard_q   <= '0;
      mag_q    <= '0;
      syn_q    <= '0;
      lrp_q    <= '0;
      tv_cnt_q <= '0;
      busy_o   <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= busy_o && last;
      if (accept) begin
        hard_q   <= hard_i;
        mag_q    <= mag_i;
        syn_q    <= syn_i;
        lrp_q    <= lrp_i;
        tv_cnt_q <= '0;
        busy_o   <= 1'b1;
      end else if (busy_o) begin
        tv_cnt_q <= tv_cnt_q + 1'b1;
        if (last) busy_o <= 1'b0;
      end
    end
  end

  chase_tv_gen #(.LR(LR)) u_gen (
    .hard_i   (hard_q),
    .syn_i    (syn_q),
    .lrp_i    (lrp_q),
    .tv_idx_i (tv_cnt_q),
    .cand_o   (cand)
  );

  chase_metric #(.MAG_W(MAG_W), .MET_W(MET_W)) u_met (
    .cand_i (cand),
    .hard_i (hard_q),
    .mag_i  (mag_q),
    .met_o  (met)
  );

  chase_select #(.WORD_W(CW_N), .MET_W(MET_W)) u_sel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (accept),
    .fold_i      (busy_o),
    .cand_i      (cand),
    .met_i       (met),
    .best_word_o (dec_word_o),
    .best_met_o  (dec_metric_o),
    .best_vld_o  (best_vld),
    .sec_word_o  (conc_word_o),
    .sec_met_o   (conc_metric_o),
    .sec_vld_o   (sec_vld)
  );

  assign conc_absent_o = best_vld && !sec_vld;
endmodule

// File: rtl/chase_tv_decoder_chk.sv
module chase_tv_decoder_chk
  import chase_pkg::*;
#(
  parameter int unsigned MET_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [CW_N-1:0]  dec_word_o,
  input logic [MET_W-1:0] dec_metric_o,
  input logic [CW_N-1:0]  conc_word_o,
  input logic [MET_W-1:0] conc_metric_o,
  input logic             conc_absent_o
);
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o); // R2
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R2
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R2
  AST_DEC_CODEWORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (word_syn(dec_word_o) == '0 && !(^dec_word_o))); // R5
  AST_CONC_CODEWORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !conc_absent_o) |-> (word_syn(conc_word_o) == '0 && !(^conc_word_o))); // R4
  AST_CONC_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !conc_absent_o) |-> dec_metric_o <= conc_metric_o); // R7
  AST_CONC_DISTINCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !conc_absent_o) |-> conc_word_o != dec_word_o); // R8
  AST_CONC_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && conc_absent_o) |-> (conc_word_o == '0 && conc_metric_o == '0)); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(dec_word_o) && $stable(conc_word_o) &&
                               $stable(conc_absent_o))); // R10
endmodule

bind chase_tv_decoder chase_tv_decoder_chk #(.MET_W(MET_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .dec_word_o    (dec_word_o),
  .dec_metric_o  (dec_metric_o),
  .conc_word_o   (conc_word_o),
  .conc_metric_o (conc_metric_o),
  .conc_absent_o (conc_absent_o)
);

// File: tb/chase_tv_decoder_tb_top.sv
module chase_tv_decoder_tb_top;
  localparam int MAG_W = 3;
  localparam int MET_W = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] hard_i = '0;
  logic [47:0] mag_i = '0;
  logic [3:0]  syn_i = '0;
  logic [7:0]  lrp_i = '0;
  logic        busy_o, done_o, conc_absent_o;
  logic [15:0] dec_word_o, conc_word_o;
  logic [7:0]  dec_metric_o, conc_metric_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2ns clk_i = ~clk_i;

  chase_tv_decoder dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .hard_i(hard_i),
    .mag_i(mag_i), .syn_i(syn_i), .lrp_i(lrp_i), .busy_o(busy_o),
    .done_o(done_o), .dec_word_o(dec_word_o), .dec_metric_o(dec_metric_o),
    .conc_word_o(conc_word_o), .conc_metric_o(conc_metric_o),
    .conc_absent_o(conc_absent_o)
  );

  function automatic logic [3:0] m_col(input int p);
    logic [3:0] v = 4'd1;
    if (p == 15) return 4'd0;
    for (int i = 0; i < p; i++) v = {v[2:0], 1'b0} ^ (v[3] ? 4'b0011 : 4'b0000);
    return v;
  endfunction

  function automatic logic [3:0] m_syn(input logic [15:0] w);
    logic [3:0] s = '0;
    for (int i = 0; i < 15; i++) if (w[i]) s ^= m_col(i);
    return s;
  endfunction

  function automatic logic [15:0] m_cand(input logic [15:0] h, input int a, input int b, input int t);
    logic [15:0] w = h;
    logic [3:0] s;
    if (t[0]) w[a] = ~w[a];
    if (t[1]) w[b] = ~w[b];
    s = m_syn(w);
    for (int j = 0; j < 15; j++) if (s != 0 && m_col(j) == s) w[j] = ~w[j];
    if (^w) w[15] = ~w[15];
    return w;
  endfunction

  function automatic logic [7:0] m_met(input logic [15:0] c, input logic [15:0] h, input logic [47:0] m);
    logic [7:0] acc = '0;
    for (int j = 0; j < 16; j++) if (c[j] != h[j]) acc += 8'(m[j*3 +: 3]);
    return acc;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_case(input logic [15:0] h, input logic [47:0] m,
                          input int a, input int b, input bit inject);
    logic [15:0] cw [4];
    logic [7:0]  cm [4];
    int di, ci;
    logic [15:0] dw, hold_dw;
    for (int t = 0; t < 4; t++) begin
      cw[t] = m_cand(h, a, b, t);
      cm[t] = m_met(cw[t], h, m);
    end
    di = 0;
    for (int t = 1; t < 4; t++) if (cm[t] < cm[di]) di = t;
    ci = -1;
    for (int t = 0; t < 4; t++)
      if (cw[t] != cw[di] && (ci < 0 || cm[t] < cm[ci])) ci = t;

    @(negedge clk_i);
    hard_i = h; mag_i = m; syn_i = m_syn(h); lrp_i = {4'(b), 4'(a)}; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R2", "busy after start", 32'(busy_o), 1);
    if (inject) begin
      // R9: second request with other data while busy
      hard_i = ~h; mag_i = ~m; syn_i = m_syn(~h); lrp_i = {4'(a), 4'(b)}; start_i = 1'b1;
    end
    repeat (3) begin
      @(negedge clk_i);
      start_i = 1'b0;
      check(done_o == 1'b0, "R2", "done early", 32'(done_o), 0);
    end
    @(negedge clk_i);
    check(done_o == 1'b1, "R2", "done pulse", 32'(done_o), 1);
    check(busy_o == 1'b0, "R2", "busy at done", 32'(busy_o), 0);
    dw = cw[di];
    check(dec_word_o == dw, inject ? "R9" : "R3", "decided word", 32'(dec_word_o), 32'(dw));
    check(dec_metric_o == cm[di], "R6", "decided metric", 32'(dec_metric_o), 32'(cm[di]));
    if (ci < 0) begin
      check(conc_absent_o == 1'b1, "R8", "absent flag", 32'(conc_absent_o), 1);
      check(conc_word_o == 16'd0 && conc_metric_o == 8'd0, "R8", "absent zero",
            {conc_word_o, 8'd0, conc_metric_o}, 0);
    end else begin
      check(conc_absent_o == 1'b0, "R8", "absent flag", 32'(conc_absent_o), 0);
      check(conc_word_o == cw[ci], "R8", "concurrent word", 32'(conc_word_o), 32'(cw[ci]));
      check(conc_metric_o == cm[ci], "R7", "concurrent metric", 32'(conc_metric_o), 32'(cm[ci]));
    end
    hold_dw = dec_word_o;
    @(negedge clk_i);
    check(done_o == 1'b0, "R2", "done one cycle", 32'(done_o), 0);
    check(dec_word_o == hold_dw, "R10", "result hold", 32'(dec_word_o), 32'(hold_dw));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(busy_o == 0 && done_o == 0 && conc_absent_o == 0, "R1", "reset flags",
          {busy_o, done_o, conc_absent_o}, 0);
    check(dec_word_o == 0 && dec_metric_o == 0, "R1", "reset decided",
          {dec_word_o, dec_metric_o}, 0);
    check(conc_word_o == 0 && conc_metric_o == 0, "R1", "reset concurrent",
          {conc_word_o, conc_metric_o}, 0);
    rst_ni = 1'b1;
    // R8 all patterns collapse to the zero word
    run_case(16'h0000, 48'h0, 0, 15, 1'b0);
    // R5 extension-bit flip with nonzero magnitudes
    run_case(16'h8000, {16{3'd5}}, 15, 3, 1'b0);
    // R4 single error in a codeword
    run_case(16'h0004, {16{3'd7}}, 2, 9, 1'b0);
    // R7 equal magnitudes force metric ties
    run_case(16'h1234, {16{3'd1}}, 4, 11, 1'b0);
    // R9 start while busy
    run_case(16'hBEEF, 48'h123456789ABC, 6, 1, 1'b1);
    for (int n = 0; n < 300; n++) begin
      int a, b;
      a = int'($urandom % 16);
      b = (a + 1 + int'($urandom % 15)) % 16;
      run_case(16'($urandom), {16'($urandom), 32'($urandom)}, a, b, n % 7 == 0);
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule